// File: doc/BRIEF.md
# Selectable 32-bit Integer Multiplier

This block is a multi-cycle multiply co-processor for the ALU of a 32-bit CPU. It takes two 32-bit operands and an operation code, and it returns one 32-bit word. That word is either the low half of the product, or the high half for signed×signed, signed×unsigned or unsigned×unsigned operands. Internally each operand is widened to 33 bits, by sign or zero extension, so one signed datapath covers all four operations.

A compile-time parameter selects the implementation, and the choice does not change any result. The serial variant is a shift-and-add engine that consumes one multiplier bit per clock, for 33 steps. The fast variant writes the product as a plain multiplication followed by a short chain of registers, which suits DSP inference. In both variants the latency is fixed and does not depend on the operands. The CPU pulses `start` while the block is idle, watches `busy`, and takes `result` in the single cycle in which `done` is high.

Top module: `mul_top`

## Requirements
- R1: Operation code 0 returns bits 31:0 of the product of `opA` and `opB`.
- R2: Operation code 1 returns bits 63:32 of the product with both operands treated as signed.
- R3: Operation code 2 returns bits 63:32 of the product with `opA` signed and `opB` unsigned.
- R4: Operation code 3 returns bits 63:32 of the product with both operands unsigned.
- R5: With `FAST_MUL`=0, `done` rises exactly 33 clock edges after the edge that accepts `start`, whatever the operand values.
- R6: With `FAST_MUL`=1, `done` rises exactly `PIPE_STAGES` (default 3) edges after the edge that accepts `start`, whatever the operand values.
- R7: `done` is high for exactly one cycle per accepted operation, `busy` is low in that cycle, and `result` stays valid until the next accepted start.
- R8: A `start` that arrives while `busy` is high is ignored. The operation in flight finishes with its own operands, operation code and timing.
- R9: After reset both `busy` and `done` are low.
- R10: Both implementations return the same result for the same operands and operation code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request an operation; accepted only when idle |
| op | input | 2 | Operation code: 0 low, 1 high s×s, 2 high s×u, 3 high u×u |
| opA | input | XLEN | Multiplicand |
| opB | input | XLEN | Multiplier |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse; `result` is valid |
| result | output | XLEN | Selected half of the product |

## Verification
The bench goes through every pair of the operands 0, 1, 2, -1, 0x7FFFFFFF and 0x80000000 in all four operations, then adds random pairs. Both implementations run side by side. A serial engine that treated bit 32 of the multiplier as a positive weight would give wrong high words whenever `opB` is negative and signed. Mixing up sign and zero extension would break only the mixed-sign and unsigned high words. Each operation's `done` time is measured, so an early exit on small operands, or a pulse longer than one cycle, shows up as a latency or pulse-count mismatch. A second start raised during the busy window would corrupt either the result or the timing if it were not ignored.

// File: rtl/mul_pkg.sv
package mul_pkg;
  localparam logic [1:0] OP_LOW  = 2'd0;
  localparam logic [1:0] OP_HISS = 2'd1;
  localparam logic [1:0] OP_HISU = 2'd2;
  localparam logic [1:0] OP_HIUU = 2'd3;

  typedef struct packed {
    logic load;
    logic step;
    logic last;
  } mulStrobes_t;
endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import mul_pkg::*;
#(
  parameter int STEPS = 33
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output logic        busy,
  output logic        done,
  output mulStrobes_t ctl
);
  localparam int CW = $clog2(STEPS + 1);

  logic          run;
  logic [CW-1:0] cnt;
  logic          lastStep;

  assign lastStep = run && (cnt == CW'(STEPS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      run  <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!run) begin
        if (start) begin
          run <= 1'b1;
          cnt <= '0;
        end
      end else begin
        cnt <= cnt + 1'b1;
        if (lastStep) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    ctl.load = !run && start;
    ctl.step = run;
    ctl.last = lastStep;
  end

  assign busy = run;

  // R7: done is a one-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);
  // R7: busy is low while done is high
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rstN) done |-> !busy);
  // R5/R6: an accepted start makes the block busy
  p_start_busy_r5: assert property (@(posedge clk) disable iff (!rstN) (start && !busy) |=> busy);
  // R8: a start while busy neither reloads nor shortens the run
  p_ignore_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !ctl.last) |=> (busy && cnt == $past(cnt) + 1'b1));
  // R6: the step counter never passes the fixed latency
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rstN) busy |-> (cnt < CW'(STEPS)));
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath
  import mul_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter bit FAST_MUL    = 1'b0,
  parameter int PIPE_STAGES = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  mulStrobes_t     ctl,
  input  logic [1:0]      op,
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  output logic [XLEN-1:0] result
);
  localparam int EXT  = XLEN + 1;
  localparam int PROD = 2 * EXT;

  logic            sgnA, sgnB;
  logic [1:0]      opSel;
  logic [PROD-1:0] prod;
  logic [PROD-2*XLEN-1:0] unusedHi;

  assign sgnA = (op == OP_HISS) || (op == OP_HISU);
  assign sgnB = (op == OP_HISS);

  always_ff @(posedge clk) begin
    if (!rstN) opSel <= OP_LOW;
    else if (ctl.load) opSel <= op;
  end

  generate
    if (FAST_MUL) begin : g_fast
      logic signed [EXT-1:0]  aReg, bReg;
      logic signed [PROD-1:0] pipe [PIPE_STAGES];

      always_ff @(posedge clk) begin
        if (ctl.load) begin
          aReg <= {sgnA & opA[XLEN-1], opA};
          bReg <= {sgnB & opB[XLEN-1], opB};
        end
        if (ctl.step) pipe[0] <= PROD'(aReg) * PROD'(bReg);
      end

      for (genvar i = 1; i < PIPE_STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
          if (ctl.step) pipe[i] <= pipe[i-1];
        end
      end

      assign prod = pipe[PIPE_STAGES-1];
    end else begin : g_serial
      logic [PROD-1:0] mcand, acc;
      logic [EXT-1:0]  mplier;

      always_ff @(posedge clk) begin
        if (ctl.load) begin
          mcand  <= {{(PROD-XLEN){sgnA & opA[XLEN-1]}}, opA};
          mplier <= {sgnB & opB[XLEN-1], opB};
          acc    <= '0;
        end else if (ctl.step) begin
          if (mplier[0]) acc <= ctl.last ? (acc - mcand) : (acc + mcand);
          mcand  <= mcand << 1;
          mplier <= mplier >> 1;
        end
      end

      assign prod = acc;

      // R5: the serial engine moves exactly one multiplier bit per step
      p_serial_shift_r5: assert property (@(posedge clk) disable iff (!rstN)
        (ctl.step && !ctl.load) |=> (mplier == ($past(mplier) >> 1)));
    end
  endgenerate

  assign unusedHi = prod[PROD-1:2*XLEN];
  assign result = (opSel == OP_LOW) ? prod[XLEN-1:0] : prod[2*XLEN-1:XLEN];

  // R8: the selected operation only changes on an accepted start
  p_opsel_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> $stable(opSel));
endmodule

// File: rtl/mul_top.sv
module mul_top
  import mul_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter bit FAST_MUL    = 1'b0,
  parameter int PIPE_STAGES = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [1:0]      op,
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  output logic            busy,
  output logic            done,
  output logic [XLEN-1:0] result
);
  localparam int STEPS = FAST_MUL ? PIPE_STAGES : XLEN + 1;

  mulStrobes_t ctl;

  mul_ctrl #(.STEPS(STEPS)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start),
    .busy(busy), .done(done), .ctl(ctl)
  );

  mul_datapath #(.XLEN(XLEN), .FAST_MUL(FAST_MUL), .PIPE_STAGES(PIPE_STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .op(op),
    .opA(opA), .opB(opB), .result(result)
  );
endmodule

// File: tb/mul_top_tb_top.sv
module mul_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SER_LAT = 33;
  localparam int FAST_LAT = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [31:0] opA = '0, opB = '0;
  logic        busyS, doneS, busyF, doneF;
  logic [31:0] resS, resF;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mul_top #(.XLEN(32), .FAST_MUL(1'b0), .PIPE_STAGES(FAST_LAT)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .op(op), .opA(opA), .opB(opB),
    .busy(busyS), .done(doneS), .result(resS)
  );

  mul_top #(.XLEN(32), .FAST_MUL(1'b1), .PIPE_STAGES(FAST_LAT)) dutFast_i (
    .clk(clk), .rstN(rstN), .start(start), .op(op), .opA(opA), .opB(opB),
    .busy(busyF), .done(doneF), .result(resF)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b, input logic [1:0] o);
    logic signed [65:0] ea, eb, p;
    bit sa, sb;
    sa = (o == 2'd1) || (o == 2'd2);
    sb = (o == 2'd1);
    ea = {{34{sa & a[31]}}, a};
    eb = {{34{sb & b[31]}}, b};
    p = ea * eb;
    return (o == 2'd0) ? p[31:0] : p[63:32];
  endfunction

  function automatic string reqOf(input logic [1:0] o);
    case (o)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic runOp(input logic [31:0] a, input logic [31:0] b, input logic [1:0] o, input bit tryStart);
    logic [31:0] exp;
    int latS, latF, cntS, cntF;
    logic [31:0] gotS, gotF;
    exp = model(a, b, o);
    latS = -1; latF = -1; cntS = 0; cntF = 0; gotS = '0; gotF = '0;
    @(negedge clk);
    start = 1'b1; op = o; opA = a; opB = b;
    @(posedge clk);
    @(negedge clk);
    if (tryStart) begin
      op = ~o; opA = ~a; opB = b + 32'd5;
    end else start = 1'b0;
    for (int k = 1; k <= SER_LAT + 3; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == 2) start = 1'b0;
      if (doneS) begin cntS++; if (latS < 0) begin latS = k; gotS = resS; end end
      if (doneF) begin cntF++; if (latF < 0) begin latF = k; gotF = resF; end end
    end
    chk(gotS == exp, {reqOf(o), " serial result"}, 64'(gotS), 64'(exp));
    chk(gotF == exp, {reqOf(o), " fast result"}, 64'(gotF), 64'(exp));
    chk(gotS == gotF, "R10 modes agree", 64'(gotS), 64'(gotF));
    chk(latS == SER_LAT, tryStart ? "R8 serial latency with busy start" : "R5 serial latency",
        64'(latS), 64'(SER_LAT));
    chk(latF == FAST_LAT, tryStart ? "R8 fast latency with busy start" : "R6 fast latency",
        64'(latF), 64'(FAST_LAT));
    chk(cntS == 1 && cntF == 1, "R7 single done pulse", 64'({cntS[15:0], cntF[15:0]}), 64'h0001_0001);
    chk(resS == exp && resF == exp, "R7 result held after done", 64'({resS, resF}), 64'({exp, exp}));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    if (!finished) $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] corners [6];
    corners[0] = 32'h0000_0000; corners[1] = 32'h0000_0001; corners[2] = 32'h0000_0002;
    corners[3] = 32'hFFFF_FFFF; corners[4] = 32'h7FFF_FFFF; corners[5] = 32'h8000_0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busyS && !doneS && !busyF && !doneF, "R9 reset state",
        64'({busyS, doneS, busyF, doneF}), 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busyS && !doneS && !busyF && !doneF, "R9 idle after reset release",
        64'({busyS, doneS, busyF, doneF}), 64'h0);
    for (int o = 0; o < 4; o++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          runOp(corners[i], corners[j], 2'(o), 1'b0);
    for (int o = 0; o < 4; o++)
      for (int n = 0; n < 100; n++)
        runOp($urandom, $urandom, 2'(o), 1'b0);
    for (int o = 0; o < 4; o++) begin
      runOp(32'h8000_0000, 32'hFFFF_FFFF, 2'(o), 1'b1);
      runOp($urandom, $urandom, 2'(o), 1'b1);
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule